// File: doc/BRIEF.md
# Sparse Carry-Tree Hybrid Adder

This block adds two unsigned operands and an incoming carry. It returns the low result bits and a carry-out. It has no clock and no state: the outputs are a pure function of the present inputs. It is intended to sit inside a datapath where a register stage on either side sets the timing.

The operands are first reduced to per-bit generate (AND) and propagate (XOR) terms. These terms are folded into one generate/propagate pair per segment of `SEG_W` bits. A radix-2 prefix tree with doubling spans then combines the segment pairs. The incoming carry is placed at the bottom of the tree as an extra node with generate equal to the carry and propagate equal to zero. The tree therefore yields only the carry into each segment, which is every fourth bit position by default, along with the final carry-out. A short ripple chain inside each segment turns its incoming carry and the per-bit terms into the sum bits.

The tree uses black cells, which produce both generate and propagate. Where the lower operand already reaches down to the carry-in node, the propagate is no longer needed, and gray cells produce the generate alone. With the default 16-bit width there are five tree nodes and three tree levels.

Top module: `sct_adder`

## Requirements
- R1: `sum_o` equals the low `WIDTH` bits of `op_a + op_b + carry_in` for every input combination.
- R2: `carry_out` equals bit `WIDTH` of `op_a + op_b + carry_in`, i.e. the group generate across all bits including the incoming carry.
- R3: With both operands zero, `sum_o` equals `carry_in` (bit 0 only) and `carry_out` is 0.
- R4: All-ones plus a carry of one, whether the one enters on `op_b` bit 0 or on `carry_in`, gives `sum_o` = 0 and `carry_out` = 1.
- R5: All-zero operands with `carry_in` = 0 give `sum_o` = 0 and `carry_out` = 0.
- R6: Alternating patterns (0xA… and 0x5… repeated nibbles) add correctly, including the case where the sum is all ones and a carry-in turns it into zero with `carry_out` = 1.
- R7: A carry generated in the lowest segment passes through every higher segment whose bits all propagate, so the carry into a fully propagating segment equals the carry out of it.
- R8: The carry that a segment's ripple chain produces at its top equals the carry that the prefix tree delivers to the next segment. A carry generated at the top bit of any segment appears as bit 0 of the next segment (or as `carry_out` for the last segment).
- R9: `WIDTH` is a parameter, any multiple of `SEG_W` (default 16; 32, 64 and 128 are intended uses), and R1 and R2 hold at each such width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Incoming carry, added at bit 0 |
| sum_o | output | WIDTH | Low `WIDTH` bits of the sum |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The bench builds two copies of the adder. One uses the default `WIDTH` of 16, which gives four segments and a three-level tree. The other uses `WIDTH` of 64, which gives sixteen segments and a five-level tree, so every gray-cell position and black cells several levels deep are exercised. Both copies are fed the same stimulus: the narrow one sees the low 16 bits. A single vector therefore checks a full-length carry chain at both depths. The 64-bit copy is also where a segment-top carry can be walked across sixteen distinct boundaries.

// File: rtl/sct_pkg.sv
`timescale 1ns/1ps
package sct_pkg;
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Prefix operator: hi is the more significant span, lo the less significant.
  function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction
endpackage

// File: rtl/sct_gp_stage.sv
`timescale 1ns/1ps
module sct_gp_stage
  import sct_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SEG_W = 4
) (
  input  logic [WIDTH-1:0]       op_a,
  input  logic [WIDTH-1:0]       op_b,
  output logic [WIDTH-1:0]       bit_g,
  output logic [WIDTH-1:0]       bit_p,
  output logic [WIDTH/SEG_W-1:0] grp_g,
  output logic [WIDTH/SEG_W-1:0] grp_p
);
  localparam int NSEG = WIDTH / SEG_W;

  always_comb begin
    bit_g = op_a & op_b;
    bit_p = op_a ^ op_b;
  end

  // Fold each segment's bit terms into one pair, lowest bit first.
  always_comb begin
    gp_t acc;
    for (int s = 0; s < NSEG; s++) begin
      acc.g = bit_g[s*SEG_W];
      acc.p = bit_p[s*SEG_W];
      for (int i = 1; i < SEG_W; i++) begin
        acc = gp_merge('{g: bit_g[s*SEG_W+i], p: bit_p[s*SEG_W+i]}, acc);
      end
      grp_g[s] = acc.g;
      grp_p[s] = acc.p;
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg_chk
    always_comb begin
      if (!$isunknown({op_a, op_b})) begin
        // R7
        grp_prop_chk: assert (grp_p[s] == (&(op_a[s*SEG_W +: SEG_W] ^ op_b[s*SEG_W +: SEG_W])))
          else $error("segment %0d propagate disagrees with operand bits", s);
      end
    end
  end
endmodule

// File: rtl/sct_prefix_tree.sv
`timescale 1ns/1ps
module sct_prefix_tree
  import sct_pkg::*;
#(
  parameter int NSEG = 4
) (
  input  logic [NSEG-1:0] grp_g,
  input  logic [NSEG-1:0] grp_p,
  input  logic            carry_in,
  output logic [NSEG:0]   seg_carry
);
  localparam int NODES  = NSEG + 1;
  localparam int LEVELS = $clog2(NODES);

  logic [NSEG:0] g_lv [LEVELS+1];
  logic [NSEG:0] p_lv [LEVELS+1];

  // Node 0 carries the external carry-in: generate = cin, propagate = 0.
  assign g_lv[0] = {grp_g, carry_in};
  assign p_lv[0] = {grp_p, 1'b0};

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    localparam int SPAN = 1 << l;
    for (genvar k = 0; k < NODES; k++) begin : g_node
      if (k < SPAN) begin : g_pass
        assign g_lv[l+1][k] = g_lv[l][k];
        assign p_lv[l+1][k] = p_lv[l][k];
      end else if (k < 2*SPAN) begin : g_gray
        // Lower operand already reaches node 0, so this result is final.
        assign g_lv[l+1][k] = g_lv[l][k] | (p_lv[l][k] & g_lv[l][k-SPAN]);
        assign p_lv[l+1][k] = 1'b0;
      end else begin : g_black
        gp_t merged;
        assign merged = gp_merge('{g: g_lv[l][k],      p: p_lv[l][k]},
                                 '{g: g_lv[l][k-SPAN], p: p_lv[l][k-SPAN]});
        assign g_lv[l+1][k] = merged.g;
        assign p_lv[l+1][k] = merged.p;
      end
    end
  end

  assign seg_carry = g_lv[LEVELS];

  always_comb begin
    if (!$isunknown({grp_g, grp_p, carry_in})) begin
      // R7
      full_prop_chk: assert (!(&grp_p) || (seg_carry[NSEG] == carry_in))
        else $error("fully propagating operands did not pass carry-in to the top");
      // R3
      base_carry_chk: assert (seg_carry[0] == carry_in)
        else $error("lowest segment does not receive carry-in");
    end
  end
endmodule

// File: rtl/sct_ripple_seg.sv
`timescale 1ns/1ps
module sct_ripple_seg #(
  parameter int SEG_W = 4
) (
  input  logic [SEG_W-1:0] seg_g,
  input  logic [SEG_W-1:0] seg_p,
  input  logic             seg_cin,
  output logic [SEG_W-1:0] seg_sum,
  output logic             seg_cout
);
  logic [SEG_W:0] c;

  assign c[0] = seg_cin;
  for (genvar i = 0; i < SEG_W; i++) begin : g_bit
    assign c[i+1] = seg_g[i] | (seg_p[i] & c[i]);
  end

  assign seg_sum  = seg_p ^ c[SEG_W-1:0];
  assign seg_cout = c[SEG_W];

  always_comb begin
    if (!$isunknown({seg_g, seg_p, seg_cin})) begin
      // R7
      seg_bypass_chk: assert (!(&seg_p) || (seg_cout == seg_cin))
        else $error("propagating segment altered its carry");
    end
  end
endmodule

// File: rtl/sct_adder.sv
`timescale 1ns/1ps
module sct_adder #(
  parameter int WIDTH = 16,
  parameter int SEG_W = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_out
);
  localparam int NSEG = WIDTH / SEG_W;

  if (WIDTH % SEG_W != 0) begin : g_bad_width
    $error("WIDTH must be a multiple of SEG_W");
  end

  logic [WIDTH-1:0] bit_g, bit_p;
  logic [NSEG-1:0]  grp_g, grp_p;
  logic [NSEG:0]    seg_carry;
  logic [NSEG-1:0]  seg_cout;

  sct_gp_stage #(.WIDTH(WIDTH), .SEG_W(SEG_W)) gp_i (
    .op_a (op_a),
    .op_b (op_b),
    .bit_g(bit_g),
    .bit_p(bit_p),
    .grp_g(grp_g),
    .grp_p(grp_p)
  );

  sct_prefix_tree #(.NSEG(NSEG)) tree_i (
    .grp_g    (grp_g),
    .grp_p    (grp_p),
    .carry_in (carry_in),
    .seg_carry(seg_carry)
  );

  for (genvar j = 0; j < NSEG; j++) begin : g_seg
    sct_ripple_seg #(.SEG_W(SEG_W)) seg_i (
      .seg_g   (bit_g[j*SEG_W +: SEG_W]),
      .seg_p   (bit_p[j*SEG_W +: SEG_W]),
      .seg_cin (seg_carry[j]),
      .seg_sum (sum_o[j*SEG_W +: SEG_W]),
      .seg_cout(seg_cout[j])
    );

    always_comb begin
      if (!$isunknown({op_a, op_b, carry_in})) begin
        // R8
        boundary_carry_chk: assert (seg_cout[j] == seg_carry[j+1])
          else $error("ripple carry of segment %0d disagrees with tree", j);
      end
    end
  end

  assign carry_out = seg_carry[NSEG];

  always_comb begin
    if (!$isunknown({op_a, op_b, carry_in})) begin
      // R1 R2
      sum_value_chk: assert ({carry_out, sum_o} ==
                             ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
        else $error("sum or carry-out wrong");
      // R3
      cin_only_chk: assert ((op_a != '0) || (op_b != '0) ||
                            ((sum_o == {{(WIDTH-1){1'b0}}, carry_in}) && !carry_out))
        else $error("carry-in alone not reflected at output");
    end
  end
endmodule

// File: tb/sct_adder_tb_top.sv
`timescale 1ns/1ps
module sct_adder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] a_n, b_n, s_n;
  logic [63:0] a_w, b_w, s_w;
  logic        cin, co_n, co_w;

  sct_adder #(.WIDTH(16), .SEG_W(4)) dut_i (
    .op_a(a_n), .op_b(b_n), .carry_in(cin), .sum_o(s_n), .carry_out(co_n)
  );
  sct_adder #(.WIDTH(64), .SEG_W(4)) dut_wide_i (
    .op_a(a_w), .op_b(b_w), .carry_in(cin), .sum_o(s_w), .carry_out(co_w)
  );

  logic [16:0] exp_n_q[$];
  logic [64:0] exp_w_q[$];
  string       tag_q[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic c, input string tag);
    logic [64:0] ew;
    logic [16:0] en;
    @(posedge clk);
    a_w = a; b_w = b; a_n = a[15:0]; b_n = b[15:0]; cin = c;
    ew = {1'b0, a} + {1'b0, b} + {64'b0, c};
    en = {1'b0, a[15:0]} + {1'b0, b[15:0]} + {16'b0, c};
    exp_w_q.push_back(ew);
    exp_n_q.push_back(en);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare away from the driving edge.
  always @(negedge clk) begin
    if (exp_n_q.size() > 0) begin
      logic [16:0] en;
      logic [64:0] ew;
      string t;
      en = exp_n_q.pop_front();
      ew = exp_w_q.pop_front();
      t  = tag_q.pop_front();
      checks++;
      if ({co_n, s_n} !== en) begin
        errors++;
        $display("FAIL %s width16: got cout=%b sum=%h exp cout=%b sum=%h", t, co_n, s_n, en[16], en[15:0]);
      end
      checks++;
      if ({co_w, s_w} !== ew) begin
        errors++;
        $display("FAIL %s width64: got cout=%b sum=%h exp cout=%b sum=%h", t, co_w, s_w, ew[64], ew[63:0]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles exp completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    a_n = '0; b_n = '0; a_w = '0; b_w = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    apply(64'h0, 64'h0, 1'b0, "R5 all zero");
    apply(64'h0, 64'h0, 1'b1, "R3 carry-in only");
    apply(~64'h0, 64'h0, 1'b1, "R4 ones plus carry-in");
    apply(~64'h0, 64'h1, 1'b0, "R4 ones plus one");
    apply(~64'h0, ~64'h0, 1'b1, "R4 ones plus ones plus carry");
    apply({16{4'hA}}, {16{4'h5}}, 1'b0, "R6 alt sum all ones");
    apply({16{4'hA}}, {16{4'h5}}, 1'b1, "R6 alt wraps to zero");
    apply({16{4'hA}}, {16{4'hA}}, 1'b0, "R6 alt doubled");
    apply({16{4'h5}}, {16{4'h5}}, 1'b1, "R6 alt low doubled");
    apply(64'h3, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0, "R7 low generate through all");
    apply(64'h5555_5555_5555_5556, 64'hAAAA_AAAA_AAAA_AAA9, 1'b1, "R7 mixed propagate chain");
    apply(64'hF0F0_F0F0_F0F0_F0F0, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1, "R7 nibble-split propagate");
    for (int k = 0; k < 16; k++) begin
      apply(64'h1 << (4*k+3), 64'h1 << (4*k+3), 1'b0, "R8 segment-top generate");
      apply(64'h1 << (4*k+3), (64'h1 << (4*k+3)) - 64'h1, 1'b1, "R8 boundary via carry-in");
    end
    for (int n = 0; n < 300; n++) begin
      apply({$urandom(), $urandom()}, {$urandom(), $urandom()}, 1'($urandom()), "R1 R2 R9 random");
    end
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule